// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block decides when a processor core leaves normal execution to service a peripheral interrupt, and then drives the fixed entry sequence. Each of `NSRC` sources presents a pending flag and a local enable. A source is requesting only when both are high. Entry starts only at an instruction boundary, and only while the block's global mask is clear.

Once entry starts, the block latches the winning source, which is the requesting source with the highest index. It then issues five stack-write strobes, one per cycle, each tagged with a register-select code. It spends one cycle setting the global mask, and then reads a two-byte service address from the vector table, high byte first. A one-cycle done pulse presents the assembled 16-bit address. The core clears the mask through `mask_clr` while the sequencer is idle.

States: `ST_IDLE` (waiting), `ST_PCL`, `ST_PCH`, `ST_XR`, `ST_AR`, `ST_CCR` (stack writes), `ST_MASK` (mask set), `ST_VHI`, `ST_VLO` (vector reads), `ST_DONE` (done pulse). Transitions:
- `ST_IDLE`→`ST_PCL` on an enabled request with the mask clear and `insn_done` high.
- Every other state advances unconditionally in the order listed.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: A source requests only when its `irq_flag` bit and its `irq_en` bit are both 1. If every source lacks one of the two, no entry starts.
- R2: From `ST_IDLE`, entry starts at a clock edge only when `gmask` is 0, `insn_done` is 1 and at least one source requests. `busy` is high from the next cycle.
- R3: In the five cycles after the accepting edge, `stk_we` is 1 and `stk_sel` is 0, 1, 2, 3, 4 in turn. The codes mean PC low, PC high, X, A and condition codes.
- R4: `gmask` stays 0 through the five stack writes. The cycle after the last write has no strobe and no read. `gmask` reads 1 from the following cycle on.
- R5: When several sources request, the one with the highest index is served, and its index appears on `src_idx`.
- R6: For served source k, the high byte is read at `VEC_TOP - 2*(NSRC-1-k)` and the low byte at that address plus 1. The reads happen in two consecutive cycles with `vec_rd` high, and `vec_data` is sampled in the same cycle as each read.
- R7: In the cycle after the low-byte read, `done` is 1 for exactly one cycle. `svc_addr` then equals {high byte, low byte} and holds that value until the next entry. `busy` is 0 the cycle after.
- R8: The served index is fixed at the accepting edge. Changes to flags or enables during the sequence do not change the addresses that are read.
- R9: While reset is asserted, the block is in `ST_IDLE` with `gmask` 1, and `stk_we`, `vec_rd`, `done` and `busy` are 0. This holds even if reset arrives in mid-sequence.
- R10: `mask_clr` clears `gmask` at a clock edge only in `ST_IDLE`. While `busy`, it has no effect, and `gmask` is 1 after the sequence ends.
- R11: A request with `insn_done` low waits without starting entry. Entry starts at the first edge where `insn_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_flag | input | NSRC | Per-source pending flags |
| irq_en | input | NSRC | Per-source local enables |
| insn_done | input | 1 | Current instruction has completed |
| mask_clr | input | 1 | Request to clear the global mask (idle only) |
| vec_data | input | 8 | Byte returned by the vector table for `vec_addr` |
| gmask | output | 1 | Global interrupt mask |
| busy | output | 1 | Entry sequence in progress |
| stk_we | output | 1 | Stack write strobe |
| stk_sel | output | 3 | Register to stack: 0 PCL, 1 PCH, 2 X, 3 A, 4 CCR |
| vec_rd | output | 1 | Vector table read strobe |
| vec_addr | output | ADDR_W | Vector table read address |
| done | output | 1 | Entry finished, service address valid |
| svc_addr | output | 16 | Assembled service routine address |
| src_idx | output | IDX_W | Index of the served source |

## Verification
The bench covers flags raised without their enables and enables without flags. A design that ORs or mixes up the two inputs would start an entry that should never occur. It drives several simultaneous requests, where a lowest-index or unlatched arbiter would read the wrong vector slot, and it swaps the requests mid-sequence to expose an index that is not latched. It also tests:
- A request held while `insn_done` is low or the mask is set, which catches a premature entry.
- A mask-clear asserted during the sequence, which catches a mask that reopens too early.
- A reset in the middle of the stack writes, which catches a block that keeps driving strobes or leaves the mask clear.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PCL,
        ST_PCH,
        ST_XR,
        ST_AR,
        ST_CCR,
        ST_MASK,
        ST_VHI,
        ST_VLO,
        ST_DONE
    } seq_state_t;

    localparam logic [2:0] SEL_PCL = 3'd0;
    localparam logic [2:0] SEL_PCH = 3'd1;
    localparam logic [2:0] SEL_X   = 3'd2;
    localparam logic [2:0] SEL_A   = 3'd3;
    localparam logic [2:0] SEL_CCR = 3'd4;

endpackage

// File: rtl/irq_req_select.sv
module irq_req_select #(
    parameter int NSRC  = 8,
    parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  flag,
    input  logic [NSRC-1:0]  en,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [NSRC-1:0] active;

    assign active = flag & en;

    // Ascending scan: the last hit is the highest index, which wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (any) begin
            // R1
            grant_valid_chk: assert (flag[idx] && en[idx]);
            for (int j = 0; j < NSRC; j++) begin
                if (j > int'(idx)) begin
                    // R5
                    top_rank_chk: assert (!(flag[j] && en[j]));
                end
            end
        end else begin
            // R1
            none_idle_chk: assert ((flag & en) == '0);
        end
    end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int               NSRC    = 8,
    parameter int               IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int               ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              lo_byte,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] TOP_RANK = ADDR_W'(NSRC - 1);

    logic [ADDR_W-1:0] rank;
    logic [ADDR_W-1:0] slot;

    // Highest index sits at the top slot; each lower rank is two bytes below.
    always_comb begin
        rank = TOP_RANK - ADDR_W'(idx);
        slot = VEC_TOP - (rank << 1);
        addr = slot + ADDR_W'(lo_byte);
    end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_any,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             insn_done,
    input  logic             mask_clr,
    input  logic [7:0]       vec_data,
    output logic             gmask,
    output logic             busy,
    output logic             stk_we,
    output logic [2:0]       stk_sel,
    output logic             vec_rd,
    output logic             vec_lo,
    output logic             done,
    output logic [15:0]      svc_addr,
    output logic [IDX_W-1:0] lat_idx
);

    seq_state_t st, nxt;
    logic       take;
    logic [7:0] hi_q;

    assign take = req_any && !gmask && insn_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (take) nxt = ST_PCL;
            ST_PCL:  nxt = ST_PCH;
            ST_PCH:  nxt = ST_XR;
            ST_XR:   nxt = ST_AR;
            ST_AR:   nxt = ST_CCR;
            ST_CCR:  nxt = ST_MASK;
            ST_MASK: nxt = ST_VHI;
            ST_VHI:  nxt = ST_VLO;
            ST_VLO:  nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stk_we  = 1'b0;
        stk_sel = SEL_PCL;
        vec_rd  = 1'b0;
        vec_lo  = 1'b0;
        done    = 1'b0;
        unique case (st)
            ST_PCL:  begin stk_we = 1'b1; stk_sel = SEL_PCL; end
            ST_PCH:  begin stk_we = 1'b1; stk_sel = SEL_PCH; end
            ST_XR:   begin stk_we = 1'b1; stk_sel = SEL_X;   end
            ST_AR:   begin stk_we = 1'b1; stk_sel = SEL_A;   end
            ST_CCR:  begin stk_we = 1'b1; stk_sel = SEL_CCR; end
            ST_VHI:  begin vec_rd = 1'b1; end
            ST_VLO:  begin vec_rd = 1'b1; vec_lo = 1'b1; end
            ST_DONE: begin done = 1'b1; end
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);

    // Mask, latched source and vector bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gmask    <= 1'b1;
            lat_idx  <= '0;
            hi_q     <= '0;
            svc_addr <= '0;
        end else begin
            if (st == ST_IDLE && take)     lat_idx <= req_idx;
            if (st == ST_MASK)             gmask   <= 1'b1;
            else if (st == ST_IDLE && mask_clr) gmask <= 1'b0;
            if (st == ST_VHI)              hi_q     <= vec_data;
            if (st == ST_VLO)              svc_addr <= {hi_q, vec_data};
        end
    end

    // R2
    entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!gmask && insn_done && req_any));

    // R3
    stack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (stk_we && stk_sel == SEL_PCL));

    // R3
    stack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && stk_sel != SEL_CCR) |=> (stk_we && stk_sel == $past(stk_sel) + 3'd1));

    // R4
    mask_open_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> !gmask);

    // R4
    mask_shut_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |-> gmask);

    // R7
    done_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(vec_rd && vec_lo));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_idx));

    // R10
    mask_no_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> !$fell(gmask));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int                NSRC    = 8,
    parameter int                IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_flag,
    input  logic [NSRC-1:0]   irq_en,
    input  logic              insn_done,
    input  logic              mask_clr,
    input  logic [7:0]        vec_data,
    output logic              gmask,
    output logic              busy,
    output logic              stk_we,
    output logic [2:0]        stk_sel,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              done,
    output logic [15:0]       svc_addr,
    output logic [IDX_W-1:0]  src_idx
);

    logic             req_any;
    logic [IDX_W-1:0] req_idx;
    logic             vec_lo;

    irq_req_select #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_sel (
        .flag (irq_flag),
        .en   (irq_en),
        .any  (req_any),
        .idx  (req_idx)
    );

    irq_entry_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_any   (req_any),
        .req_idx   (req_idx),
        .insn_done (insn_done),
        .mask_clr  (mask_clr),
        .vec_data  (vec_data),
        .gmask     (gmask),
        .busy      (busy),
        .stk_we    (stk_we),
        .stk_sel   (stk_sel),
        .vec_rd    (vec_rd),
        .vec_lo    (vec_lo),
        .done      (done),
        .svc_addr  (svc_addr),
        .lat_idx   (src_idx)
    );

    irq_vec_addr #(
        .NSRC    (NSRC),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W),
        .VEC_TOP (VEC_TOP)
    ) u_vec (
        .idx     (src_idx),
        .lo_byte (vec_lo),
        .addr    (vec_addr)
    );

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_flag = '0;
    logic [7:0]  irq_en = '0;
    logic        insn_done = 1'b0;
    logic        mask_clr = 1'b0;
    logic [7:0]  vec_data;
    logic        gmask, busy, stk_we, vec_rd, done;
    logic [2:0]  stk_sel;
    logic [15:0] vec_addr, svc_addr;
    logic [2:0]  src_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    function automatic logic [15:0] slot(input int k);
        return 16'hFFFE - 16'(2 * (NS - 1 - k));
    endfunction

    assign vec_data = mem(vec_addr);

    irq_entry_seq u_dut (
        .clk (clk), .rst_n (rst_n), .irq_flag (irq_flag), .irq_en (irq_en),
        .insn_done (insn_done), .mask_clr (mask_clr), .vec_data (vec_data),
        .gmask (gmask), .busy (busy), .stk_we (stk_we), .stk_sel (stk_sel),
        .vec_rd (vec_rd), .vec_addr (vec_addr), .done (done),
        .svc_addr (svc_addr), .src_idx (src_idx)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mask();
        @(negedge clk); mask_clr = 1'b1;
        @(negedge clk); mask_clr = 1'b0;
        chk(gmask == 1'b0, "R10 mask clears in idle", gmask, 0);
    endtask

    // mode 0 plain, 1 swap requests mid-sequence, 2 hold mask_clr during sequence
    task automatic run_seq(input int k, input int mode);
        logic [15:0] a;
        a = slot(k);
        @(negedge clk);
        chk(busy, "R2 entry taken", busy, 1);
        chk(stk_we && stk_sel == 3'd0, "R3 first write PCL", {stk_we, stk_sel}, 4'h8);
        insn_done = 1'b0;
        if (mode == 1) begin irq_flag = 8'h80; irq_en = 8'hFF; end
        if (mode == 2) mask_clr = 1'b1;
        for (int s = 1; s < 5; s++) begin
            @(negedge clk);
            chk(stk_we && stk_sel == 3'(s), "R3 stack order", {stk_we, stk_sel}, 8 + s);
            chk(!gmask, "R4 mask open while stacking", gmask, 0);
        end
        @(negedge clk);
        chk(!stk_we && !vec_rd, "R4 mask cycle idle strobes", {stk_we, vec_rd}, 0);
        @(negedge clk);
        chk(gmask, "R4 mask set before vector read", gmask, 1);
        chk(vec_rd && vec_addr == a, "R6 high byte address", vec_addr, a);
        @(negedge clk);
        chk(vec_rd && vec_addr == a + 16'd1, "R6 low byte address", vec_addr, a + 16'd1);
        if (mode == 2) mask_clr = 1'b0;
        @(negedge clk);
        chk(done && svc_addr == {mem(a), mem(a + 16'd1)}, "R7 done and service address",
            svc_addr, {mem(a), mem(a + 16'd1)});
        chk(src_idx == 3'(k), "R5 R8 served index", src_idx, k);
        @(negedge clk);
        chk(!done && !busy, "R7 single done pulse", {done, busy}, 0);
        chk(svc_addr == {mem(a), mem(a + 16'd1)}, "R7 address held", svc_addr,
            {mem(a), mem(a + 16'd1)});
    endtask

    // {flags, enables, take, index}
    localparam logic [19:0] TBL [0:8] = '{
        {8'h01, 8'h01, 1'b1, 3'd0},
        {8'h81, 8'hFF, 1'b1, 3'd7},
        {8'h81, 8'h01, 1'b1, 3'd0},
        {8'h3C, 8'h3C, 1'b1, 3'd5},
        {8'hFF, 8'h00, 1'b0, 3'd0},
        {8'h00, 8'hFF, 1'b0, 3'd0},
        {8'h0A, 8'h08, 1'b1, 3'd3},
        {8'h55, 8'hAA, 1'b0, 3'd0},
        {8'h46, 8'h06, 1'b1, 3'd2}
    };

    initial begin
        // R9 reset state
        repeat (2) @(negedge clk);
        chk(gmask && !busy && !stk_we && !vec_rd && !done, "R9 reset state",
            {gmask, busy, stk_we, vec_rd, done}, 5'b10000);
        rst_n = 1'b1;

        // R2 mask set blocks entry
        irq_flag = 8'h01; irq_en = 8'h01; insn_done = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !stk_we, "R2 blocked by mask", {busy, stk_we}, 0);
        irq_flag = '0; irq_en = '0; insn_done = 1'b0;

        for (int i = 0; i < 9; i++) begin
            clear_mask();
            irq_flag = TBL[i][19:12]; irq_en = TBL[i][11:4]; insn_done = 1'b1;
            if (TBL[i][3]) begin
                run_seq(int'(TBL[i][2:0]), 0);
            end else begin
                repeat (3) @(negedge clk);
                chk(!busy && !stk_we, "R1 no request without flag and enable",
                    {busy, stk_we}, 0);
            end
            irq_flag = '0; irq_en = '0; insn_done = 1'b0;
        end

        // R11 wait for instruction boundary
        clear_mask();
        irq_flag = 8'h10; irq_en = 8'h10;
        repeat (3) @(negedge clk);
        chk(!busy && !stk_we, "R11 waits for insn_done", {busy, stk_we}, 0);
        insn_done = 1'b1;
        run_seq(4, 0);
        irq_flag = '0; irq_en = '0;

        // R8 requests swapped mid-sequence
        clear_mask();
        irq_flag = 8'h04; irq_en = 8'hFF; insn_done = 1'b1;
        run_seq(2, 1);
        irq_flag = '0; irq_en = '0;

        // R10 mask_clr ignored while busy
        clear_mask();
        irq_flag = 8'h02; irq_en = 8'h02; insn_done = 1'b1;
        run_seq(1, 2);
        chk(gmask, "R10 mask_clr ignored while busy", gmask, 1);
        irq_flag = '0; irq_en = '0;

        // R9 reset mid-sequence
        clear_mask();
        irq_flag = 8'h08; irq_en = 8'h08; insn_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        insn_done = 1'b0;
        @(negedge clk);
        chk(!busy && !stk_we && gmask, "R9 reset mid-sequence",
            {busy, stk_we, gmask}, 3'b001);
        rst_n = 1'b1;
        irq_flag = '0; irq_en = '0;
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule